// File: doc/BRIEF.md
# Binary Rate Multiplier Oscillator with Quadrature Phases

This block is a digitally controlled oscillator for a carrier tracking loop. A free-running binary counter advances on every clock. Whenever a counter bit goes from 0 to 1, that rising edge is passed on only if the matching bit of a rate word is set. The surviving edges are merged into one pulse stream. Over each full counter period, the stream carries exactly as many pulses as the value of the rate word. A processor can rewrite the rate word at any time. The block takes the new value only at the start of a counter period, so one period never mixes two words.

A two-stage Johnson counter follows the pulse stream and advances once per pulse. It produces an in-phase and a quadrature square wave at one quarter of the pulse rate, with the quadrature output lagging by 90 degrees. These two waves drive the phase detectors downstream.

The counter is made of cascaded 2-bit slices that share one clock, with the carry rippling combinationally between slices. Every output comes straight from a flip-flop. The logic is a few gate levels deep, far shorter than a 2.5 MHz clock period requires.

Top module: `brm_osc`

## Requirements
- R1: While `rst` is high at a clock edge, `rate_pulse`, `phase_i` and `phase_q` are 0 after that edge. The counter restarts at count 0, and the held rate word is cleared.
- R2: For a held rate word N, the block emits exactly N pulses over the 2^RATE_W - 1 clocks that follow the clock on which the word is taken. RATE_W defaults to 18.
- R3: Let count v be nonzero, and let its lowest set bit be at position k. Then `rate_pulse` is high in the cycle after the counter holds v exactly when bit RATE_W-1-k of the held word is 1. For example, if only the top bit is set, a pulse follows every odd count.
- R4: `rate_word` is sampled only on the clock edge at which the counter leaves count 0. A change made during a period has no effect on that period's pulse count.
- R5: A held word of zero gives no pulses, and `phase_i`/`phase_q` stay constant.
- R6: {phase_i, phase_q} steps through 00, 10, 11, 01 and back to 00, one step on the clock after each cycle in which `rate_pulse` is high. It holds at all other times.
- R7: An all-ones word gives a pulse after every count except count 0, which is 2^RATE_W - 1 pulses per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_word | input | RATE_W | Rate control word, taken at each counter period start |
| rate_pulse | output | 1 | Rate-controlled pulse stream, one clock wide per pulse |
| phase_i | output | 1 | In-phase square wave |
| phase_q | output | 1 | Quadrature square wave, lagging phase_i by 90 degrees |

## Verification
The assertions assume that `rst` is held high across at least one clock edge before checking begins, and that `rate_word` is settled at the edge where the counter leaves zero. The bench meets both conditions by driving every input on the falling clock edge and by opening with a multi-cycle reset. The assertions place no limit on when `rate_word` may change, and the bench deliberately rewrites it in the middle of a period. The bench builds the counter with an 8-bit word so that many full periods fit in a short run. It checks the all-zero word, a single-bit word, the all-ones word and a mixed word, and it applies one reset in the middle of the run.

// File: rtl/brm_pkg.sv
package brm_pkg;
  // Johnson states written as {in-phase, quadrature}
  typedef enum logic [1:0] {
    QP_0   = 2'b00,
    QP_90  = 2'b10,
    QP_180 = 2'b11,
    QP_270 = 2'b01
  } quad_t;

  function automatic quad_t quad_next(input quad_t cur);
    return quad_t'({~cur[0], cur[1]});
  endfunction
endpackage

// File: rtl/brm_cnt_slice.sv
module brm_cnt_slice #(
  parameter int SLICE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cin,
  output logic [SLICE_W-1:0] q,
  output logic               full
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q + SLICE_W'(cin);
  end

  assign full = &q;
endmodule

// File: rtl/brm_counter.sv
module brm_counter #(
  parameter int RATE_W = 18,
  parameter int SLICE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [RATE_W-1:0] cnt,
  output logic              at_zero
);
  localparam int NSLICE = RATE_W / SLICE_W;

  logic [NSLICE:0]   carry;
  logic [NSLICE-1:0] full;

  assign carry[0] = 1'b1;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    brm_cnt_slice #(.SLICE_W(SLICE_W)) u_slice (
      .clk  (clk),
      .rst  (rst),
      .cin  (carry[s]),
      .q    (cnt[s*SLICE_W +: SLICE_W]),
      .full (full[s])
    );
    assign carry[s+1] = carry[s] & full[s];
  end

  // carry out of the top slice means the count wraps on this edge
  always_ff @(posedge clk) begin
    if (rst) at_zero <= 1'b1;
    else     at_zero <= carry[NSLICE];
  end
endmodule

// File: rtl/brm_gate.sv
module brm_gate #(
  parameter int RATE_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] cnt,
  input  logic              at_zero,
  input  logic [RATE_W-1:0] rate_word,
  output logic [RATE_W-1:0] held_word,
  output logic              pulse
);
  logic [RATE_W-1:0] cnt_d;
  logic [RATE_W-1:0] rise;
  logic [RATE_W-1:0] weight;

  assign rise = cnt & ~cnt_d;

  // the fastest counter bit pairs with the heaviest word bit
  for (genvar k = 0; k < RATE_W; k++) begin : g_map
    assign weight[k] = held_word[RATE_W-1-k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_d     <= '0;
      held_word <= '0;
      pulse     <= 1'b0;
    end else begin
      cnt_d <= cnt;
      pulse <= |(rise & weight);
      if (at_zero) held_word <= rate_word;
    end
  end
endmodule

// File: rtl/brm_quad.sv
module brm_quad
  import brm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic ph_i,
  output logic ph_q
);
  quad_t st;

  always_ff @(posedge clk) begin
    if (rst)       st <= QP_0;
    else if (step) st <= quad_next(st);
  end

  assign ph_i = st[1];
  assign ph_q = st[0];
endmodule

// File: rtl/brm_osc.sv
module brm_osc #(
  parameter int RATE_W = 18,
  parameter int SLICE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_word,
  output logic              rate_pulse,
  output logic              phase_i,
  output logic              phase_q
);
  logic [RATE_W-1:0] cnt;
  logic [RATE_W-1:0] held_word;
  logic              at_zero;

  brm_counter #(.RATE_W(RATE_W), .SLICE_W(SLICE_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .at_zero (at_zero)
  );

  brm_gate #(.RATE_W(RATE_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt),
    .at_zero   (at_zero),
    .rate_word (rate_word),
    .held_word (held_word),
    .pulse     (rate_pulse)
  );

  brm_quad u_quad (
    .clk  (clk),
    .rst  (rst),
    .step (rate_pulse),
    .ph_i (phase_i),
    .ph_q (phase_q)
  );
endmodule

// File: rtl/brm_osc_chk.sv
module brm_osc_chk #(
  parameter int RATE_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic [RATE_W-1:0] cnt,
  input logic [RATE_W-1:0] held_word,
  input logic              rate_pulse,
  input logic              phase_i,
  input logic              phase_q
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rate_pulse && !phase_i && !phase_q && cnt == '0 && held_word == '0));

  a_r4_word_hold: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(held_word));

  a_r3_no_pulse_at_zero: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> !rate_pulse);

  a_r5_zero_silent: assert property (@(posedge clk) disable iff (rst)
    (held_word == '0) |=> !rate_pulse);

  a_r6_quad_step: assert property (@(posedge clk) disable iff (rst)
    rate_pulse |=> ($countones({phase_i, phase_q} ^ $past({phase_i, phase_q})) == 1));

  a_r6_quad_hold: assert property (@(posedge clk) disable iff (rst)
    !rate_pulse |=> $stable({phase_i, phase_q}));

  a_r6_direction: assert property (@(posedge clk) disable iff (rst)
    (rate_pulse && !phase_i && !phase_q) |=> (phase_i && !phase_q));
endmodule

bind brm_osc brm_osc_chk #(.RATE_W(RATE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt        (cnt),
  .held_word  (held_word),
  .rate_pulse (rate_pulse),
  .phase_i    (phase_i),
  .phase_q    (phase_q)
);

// File: tb/sim_brm_osc.sv
module sim_brm_osc;
  localparam int W = 8;
  localparam int P = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] rate_word = '0;
  logic         rate_pulse, phase_i, phase_q;

  int n_run = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  brm_osc #(.RATE_W(W), .SLICE_W(2)) u0 (
    .clk(clk), .rst(rst), .rate_word(rate_word),
    .rate_pulse(rate_pulse), .phase_i(phase_i), .phase_q(phase_q)
  );

  // behavioural reference: count value, taken word, last pulse, quarter-phase index
  int m_cnt = 0, m_word = 0, m_ph = 0;
  bit m_pulse = 1'b0;

  function automatic int low_bit(input int v);
    for (int b = 0; b < 32; b++) if (v[b]) return b;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_word = 0; m_ph = 0; m_pulse = 1'b0;
    end else begin
      if (m_pulse) m_ph = (m_ph + 1) % 4;
      if (m_cnt == 0) m_pulse = 1'b0;
      else            m_pulse = ((m_word >> (W - 1 - low_bit(m_cnt))) & 1) == 1;
      if (m_cnt == 0) m_word = rate_word;
      m_cnt = (m_cnt + 1) % P;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference (R3 pulses, R6 phases)
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(rate_pulse == m_pulse, "R3 pulse", rate_pulse, m_pulse);
      check({phase_i, phase_q} == expected_iq(m_ph), "R6 phase",
            {phase_i, phase_q}, expected_iq(m_ph));
    end
  end

  function automatic logic [1:0] expected_iq(input int ph);
    case (ph)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  // run one full period with word n; optionally rewrite the word mid-period
  task automatic period(input int n, input int mid, input bit do_mid, input string req);
    int got = 0;
    logic [1:0] iq0;
    rate_word = W'(n);
    do @(negedge clk); while (m_cnt != 1);
    iq0 = {phase_i, phase_q};
    for (int c = 0; c < P - 1; c++) begin
      @(negedge clk);
      if (do_mid && c == 100) rate_word = W'(mid);
      if (rate_pulse) got++;
    end
    check(got == n, req, got, n);
    if (n == 0) check({phase_i, phase_q} == iq0, "R5 phases frozen", {phase_i, phase_q}, iq0);
  endtask

  initial begin
    repeat (5000000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({rate_pulse, phase_i, phase_q} == 3'b000, "R1 reset outputs",
          {rate_pulse, phase_i, phase_q}, 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    period(0, 0, 1'b0, "R5 zero word count");
    period(0, 0, 1'b0, "R5 zero word count");
    period(8'h80, 0, 1'b0, "R3 top-bit word count");
    period(8'hFF, 0, 1'b0, "R7 all-ones count");
    period(8'h5A, 0, 1'b0, "R2 mixed word count");
    period(8'h01, 0, 1'b0, "R2 single pulse count");
    period(8'h37, 8'hC4, 1'b1, "R4 mid-period change ignored");
    period(8'hC4, 0, 1'b0, "R4 new word next period");
    period(8'h6B, 0, 1'b0, "R2 second mixed word count");
    // reset in the middle of a period
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({rate_pulse, phase_i, phase_q} == 3'b000, "R1 mid-run reset",
          {rate_pulse, phase_i, phase_q}, 0);
    rst = 1'b0;
    period(8'hAA, 0, 1'b0, "R1 count after reset");
    period(8'hFF, 0, 1'b0, "R7 all-ones count again");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule